// File: doc/BRIEF.md
# Fractional Byte-Clock and Packet Slot Generator

This block derives a transport-rate byte strobe from a faster processing clock. A phase accumulator advances by a programmable frequency word on every processing-clock cycle. Each wrap of the accumulator produces a one-cycle byte strobe. The gap between strobes is therefore always a whole number of processing cycles, and it alternates between two neighbouring lengths so that the long-run rate matches the programmed one.

The strobes are grouped into packet slots of 204 bytes. The first 188 bytes of each slot carry data and are flagged valid. The last 16 are gap bytes, sent as zero and flagged invalid. Data bytes come from a producer through a 16-entry FIFO with a ready/write handshake, so the producer does not need to follow strobe timing. One byte leaves the FIFO on each valid slot. If the FIFO is empty on a valid slot, an underflow pulse is raised.

Top module: `byte_strobe_gen`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the slot position and the FIFO. After reset, byteEn, dataValid, dataOut and underflow are 0 and wrReady is 1. The first strobe after reset is slot 0 of a frame.
- R2: The accumulator is 32 bits wide. byteEn is high in the cycle after an addition that carries out, and low otherwise. After n cycles out of reset at a constant word F, the number of strobes seen is floor(n*F/2^32).
- R3: At a constant nonzero word F, the distance between consecutive strobes is floor(2^32/F) or that value plus one cycles.
- R4: A frequency word of zero produces no strobes.
- R5: Strobes number slots 0 to 203 and then wrap to 0. dataValid is 1 on slots 0 to 187 and 0 on slots 188 to 203.
- R6: dataValid and dataOut change only in cycles where byteEn is high, and hold their values otherwise.
- R7: Each valid slot presents the oldest FIFO byte on dataOut and removes it from the FIFO. Gap slots present 0 and leave the FIFO untouched.
- R8: A valid slot that finds the FIFO empty raises underflow for that strobe cycle only, with dataOut 0 and dataValid 1.
- R9: wrReady is 0 while the FIFO holds 16 bytes. A write offered while wrReady is 0 is dropped.
- R10: A new frequency word is used from the next cycle on. The accumulator phase is kept, so the strobe count follows the running sum of all words applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | 32 | Phase increment added every cycle |
| wrData | input | 8 | Byte offered by the producer |
| wrEn | input | 1 | Write request for wrData |
| wrReady | output | 1 | FIFO can take a byte this cycle |
| byteEn | output | 1 | One-cycle byte strobe |
| dataValid | output | 1 | Current slot carries data |
| dataOut | output | 8 | Byte of the current slot |
| underflow | output | 1 | Valid slot found the FIFO empty |

## Verification
The bench tracks the total phase as an exact running sum. This catches a carry taken from the wrong bit, a phase lost when the word changes, and strobes that drift by one cycle. It runs full frames past the 204-slot wrap, so a frame boundary placed one slot off shows up as a misplaced or missing gap byte. Words close to the maximum give back-to-back strobes and make pushes and pops meet on the same edge; a FIFO count that mishandles this loses or repeats a byte. Filling the FIFO with strobes stopped and then draining it with the producer halted shows whether writes are wrongly accepted when full and whether an empty valid slot outputs stale data instead of an underflow with zero.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  // Per-cycle control handed from the strobe/framing logic to the datapath
  typedef struct packed {
    logic tick;       // accumulator carried out this cycle
    logic slotValid;  // the slot being issued belongs to the data part
  } bsgCtrl_t;
endpackage

// File: rtl/bsg_ctrl.sv
module bsg_ctrl
  import bsg_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int FRAME_LEN = 204,
  parameter int VALID_LEN = 188
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freqWord,
  output bsgCtrl_t         ctrl
);
  localparam int SLOT_W = $clog2(FRAME_LEN);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] DATA_SLOTS = SLOT_W'(VALID_LEN);

  logic [ACC_W-1:0]  phaseAcc;
  logic [ACC_W:0]    phaseSum;
  logic [SLOT_W-1:0] slotIdx;

  // Add with carry out; the carry is the byte tick
  assign phaseSum = {1'b0, phaseAcc} + {1'b0, freqWord};

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
    end else begin
      phaseAcc <= phaseSum[ACC_W-1:0];
    end
  end

  // slotIdx names the slot that the next tick will issue
  always_ff @(posedge clk) begin
    if (rst) begin
      slotIdx <= '0;
    end else if (phaseSum[ACC_W]) begin
      slotIdx <= (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
    end
  end

  always_comb begin
    ctrl.tick      = phaseSum[ACC_W];
    ctrl.slotValid = (slotIdx < DATA_SLOTS);
  end
endmodule

// File: rtl/bsg_datapath.sv
module bsg_datapath
  import bsg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bsgCtrl_t          ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic              wrReady,
  output logic              byteEn,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              underflow
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fillCnt;
  logic              fifoFull, fifoEmpty, doPush, doPop, starved;

  assign fifoFull  = (fillCnt == FULL_CNT);
  assign fifoEmpty = (fillCnt == '0);
  assign wrReady   = !fifoFull;
  assign doPush    = wrEn && !fifoFull;
  assign doPop     = ctrl.tick && ctrl.slotValid && !fifoEmpty;
  assign starved   = ctrl.tick && ctrl.slotValid && fifoEmpty;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      fillCnt <= fillCnt + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // Output stage: loads only on a tick, holds otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      byteEn    <= 1'b0;
      dataValid <= 1'b0;
      dataOut   <= '0;
      underflow <= 1'b0;
    end else begin
      byteEn    <= ctrl.tick;
      underflow <= starved;
      if (ctrl.tick) begin
        dataValid <= ctrl.slotValid;
        dataOut   <= doPop ? fifoMem[rdPtr] : '0;
      end
    end
  end
endmodule

// File: rtl/byte_strobe_gen.sv
module byte_strobe_gen
  import bsg_pkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int FRAME_LEN  = 204,
  parameter int VALID_LEN  = 188
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freqWord,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic              wrReady,
  output logic              byteEn,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              underflow
);
  bsgCtrl_t ctrlBus;

  bsg_ctrl #(
    .ACC_W(ACC_W), .FRAME_LEN(FRAME_LEN), .VALID_LEN(VALID_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .freqWord(freqWord), .ctrl(ctrlBus)
  );

  bsg_datapath #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus),
    .wrData(wrData), .wrEn(wrEn), .wrReady(wrReady),
    .byteEn(byteEn), .dataValid(dataValid), .dataOut(dataOut),
    .underflow(underflow)
  );
endmodule

// File: rtl/byte_strobe_gen_chk.sv
module byte_strobe_gen_chk #(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  freqWord,
  input logic              byteEn,
  input logic              dataValid,
  input logic [DATA_W-1:0] dataOut,
  input logic              underflow
);
  // R4: zero word in the previous cycle gives no strobe
  a_r4_zero_word_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(freqWord) == '0) |-> !byteEn);

  // R6: outputs hold between strobes
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    !byteEn |-> ($stable(dataOut) && $stable(dataValid)));

  // R8: underflow only on a valid strobe, with zero data
  a_r8_underflow_shape: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (byteEn && dataValid && dataOut == '0));

  // R7: gap slots carry zero and never underflow
  a_r7_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (byteEn && !dataValid) |-> (dataOut == '0 && !underflow));

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!byteEn && !underflow));
endmodule

bind byte_strobe_gen byte_strobe_gen_chk #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .freqWord(freqWord), .byteEn(byteEn),
  .dataValid(dataValid), .dataOut(dataOut), .underflow(underflow)
);

// File: tb/byte_strobe_gen_tb.sv
`timescale 1ns/1ps
module byte_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freqWord = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        wrReady, byteEn, dataValid, underflow;
  logic [7:0]  dataOut;

  byte_strobe_gen u_dut (
    .clk(clk), .rst(rst), .freqWord(freqWord), .wrData(wrData), .wrEn(wrEn),
    .wrReady(wrReady), .byteEn(byteEn), .dataValid(dataValid),
    .dataOut(dataOut), .underflow(underflow)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model state
  longint unsigned phaseTotal;
  longint unsigned stCount;
  logic [7:0] q [4096];
  int qHead, qTail;
  logic prevValid;
  logic [7:0] prevOut;
  logic [7:0] nextByte;
  bit feedOn;
  int cyc, lastStrobe;
  bit spacingOk;
  int underflowSeen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phaseTotal = 0; stCount = 0; qHead = 0; qTail = 0;
    prevValid = 0; prevOut = 0; cyc = 0; lastStrobe = -1; spacingOk = 0;
    // R1: reset state
    chk(byteEn == 0,    "R1 byteEn",    byteEn, 0);
    chk(dataValid == 0, "R1 dataValid", dataValid, 0);
    chk(dataOut == 0,   "R1 dataOut",   dataOut, 0);
    chk(underflow == 0, "R1 underflow", underflow, 0);
    chk(wrReady == 1,   "R1 wrReady",   wrReady, 1);
  endtask

  task automatic setWord(input logic [31:0] w);
    freqWord = w;
    spacingOk = 0;
  endtask

  // One processing cycle: called at a negedge, returns at the next negedge
  task automatic step();
    bit accepted, strobe;
    logic [7:0] written;
    longint unsigned newCount;
    int slot;
    wrEn = feedOn;
    wrData = nextByte;
    accepted = wrEn && wrReady;
    written = wrData;
    phaseTotal += longint'(freqWord);
    newCount = phaseTotal >> 32;
    strobe = (newCount != stCount);
    stCount = newCount;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    nextByte = nextByte + 8'd1;
    chk(byteEn == strobe, "R2 strobe timing", byteEn, strobe);  // R10 via running sum
    if (strobe) begin
      if (spacingOk && lastStrobe >= 0) begin
        int k = int'(64'h1_0000_0000 / longint'(freqWord));
        int gap = cyc - lastStrobe;
        chk(gap == k || gap == k + 1, "R3 strobe spacing", gap, k);
      end
      lastStrobe = cyc;
      spacingOk = 1;
      slot = int'((newCount - 1) % 204);
      if (newCount == 1) chk(dataValid == 1, "R1 first slot is 0", dataValid, 1);
      chk(dataValid == (slot < 188), "R5 slot framing", dataValid, slot < 188);
      if (slot < 188) begin
        if (qHead == qTail) begin
          chk(underflow == 1, "R8 underflow flag", underflow, 1);
          chk(dataOut == 0,   "R8 underflow data", dataOut, 0);
          underflowSeen++;
        end else begin
          chk(dataOut == q[qHead % 4096], "R7 fifo order", dataOut, q[qHead % 4096]);
          chk(underflow == 0, "R8 no false underflow", underflow, 0);
          qHead++;
        end
      end else begin
        chk(dataOut == 0 && underflow == 0, "R7 gap slot zero", dataOut, 0);
      end
    end else begin
      chk(dataValid == prevValid && dataOut == prevOut, "R6 hold", dataOut, prevOut);
      chk(underflow == 0, "R8 no pulse off strobe", underflow, 0);
    end
    prevValid = dataValid;
    prevOut = dataOut;
    if (accepted) begin
      q[qTail % 4096] = written;
      qTail++;
    end
  endtask

  initial begin
    nextByte = 8'h10; feedOn = 0; underflowSeen = 0;
    @(negedge clk);
    doReset();

    // R4 and R9: no strobes, FIFO fills, excess writes dropped
    setWord(32'h0);
    feedOn = 1;
    repeat (40) step();
    chk(wrReady == 0, "R9 full deasserts ready", wrReady, 0);
    chk(qTail - qHead == 16, "R9 sixteen held", qTail - qHead, 16);
    chk(byteEn == 0, "R4 zero word no strobe", byteEn, 0);

    // Main run: rate near one fifth, several frames and wraps (R2 R3 R5 R7)
    setWord(32'h3333_3334);
    repeat (2300) step();

    // R10: change word mid-run, phase kept; then starve for R8
    setWord(32'h9000_0000);
    repeat (100) step();
    feedOn = 0;
    repeat (500) step();
    chk(underflowSeen > 0, "R8 underflow exercised", underflowSeen, 1);

    // Back-to-back strobes with simultaneous push/pop
    feedOn = 1;
    setWord(32'hFFFF_FFFF);
    repeat (600) step();

    // Reset mid-stream returns to slot 0 with an empty FIFO (R1)
    feedOn = 0;
    doReset();
    setWord(32'h4000_0000);
    repeat (20) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule